// File: doc/BRIEF.md
# Layered Overcurrent Fault Supervisor

This block watches the current of one power rail built from up to eight phases and decides when the pulse-width modulators and synchronous rectifiers of those phases must be switched off. Three protection tiers feed it. The fastest is a per-phase fault pin driven by an external gate driver. The next is a per-phase trip from an analog current comparator. The slowest is a stream of digitised per-phase current samples. Each phase's samples are smoothed into a running average, the averages are added into a rail current, and the sum is checked against an overcurrent limit and a negative undercurrent limit.

The pin and comparator tiers reach the disable outputs through logic alone, with no register on the path, so the outputs turn off in the same cycle as the input. The averaged tier is registered and acts a few cycles after the sample that crosses a limit. Each tier has its own response setting. It can be ignored, it can shut the outputs off until software clears the status, or it can shut them off for a programmable wait and then restart them, with a bounded number of restarts. Each rectifier disable follows its PWM disable after a programmable number of cycles. Sticky status bits and a maskable alert report what happened.

Top module: `phase_fault_sup`

## Requirements
- R1: While any bit of `ext_flt_i` is high and the pin response is not ignore, every bit of `pwm_dis_o` is high in the same cycle, with no clock edge in between.
- R2: While `cmp_trip_i[k]` is high and the comparator response is not ignore, `pwm_dis_o[k]` is high in the same cycle, and the trip sets no disable on any other phase.
- R3: `sre_dis_o[k]` is never high without `pwm_dis_o[k]`. It rises on the D-th rising edge after `pwm_dis_o[k]` went high and stays high while `pwm_dis_o[k]` stays high, where D is `cfg_sre_dly_i`. With D = 0 it follows `pwm_dis_o[k]` at once.
- R4: Each sample accepted with `smp_vld_i` high updates the average of the phase selected by `smp_ph_i`: avg <= avg + ((x - avg) >>> `cfg_shift_i`), using signed arithmetic. Shift 0 makes the average equal to the sample.
- R5: The rail sum is the signed sum of all phase averages. A sum strictly above `cfg_oc_lim_i` is an overcurrent, and a sum strictly below `cfg_uc_lim_i` is an undercurrent. Both use the averaged-tier response. The outputs switch off on the third rising edge counted from the edge that takes the crossing sample, so a sum equal to a limit trips nothing.
- R6: Response codes: 2'b00 = ignore, so the tier sets no status and disables nothing. 2'b01 or 2'b11 = latch, so the outputs stay off until all status bits read zero and are re-enabled on the next edge. 2'b10 = retry.
- R7: In retry, the disabled outputs are re-enabled on the `cfg_retry_dly_i`-th edge after the edge that registered the fault, and the restart count goes up by one. A retry fault that arrives when the count already equals `cfg_retry_max_i` latches instead. Releasing a latch sets the count back to zero.
- R8: `status_o` bits are bit0 pin fault, bit1 comparator trip, bit2 overcurrent and bit3 undercurrent. Each bit is set on the edge after its tier fires and stays set until a `sts_clr_i` pulse writes a 1 to that bit. A set in the same cycle wins over a clear.
- R9: `alert_o` is high exactly while a status bit is set whose `sts_mask_i` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_flt_i | input | NPH | External fault pins, one per phase |
| cmp_trip_i | input | NPH | Fast comparator trips, one per phase |
| smp_vld_i | input | 1 | Current sample valid |
| smp_ph_i | input | PHW | Phase index of the sample |
| smp_data_i | input | DW | Signed current sample |
| cfg_shift_i | input | SW | Averaging shift factor |
| cfg_oc_lim_i | input | SUMW | Signed rail overcurrent limit |
| cfg_uc_lim_i | input | SUMW | Signed rail undercurrent limit (negative) |
| cfg_rsp_pin_i | input | 2 | Response to pin faults |
| cfg_rsp_cmp_i | input | 2 | Response to comparator trips |
| cfg_rsp_avg_i | input | 2 | Response to averaged-limit faults |
| cfg_retry_dly_i | input | TW | Retry wait in clock cycles |
| cfg_retry_max_i | input | RCW | Number of restarts allowed |
| cfg_sre_dly_i | input | DLW | Rectifier disable lag in cycles |
| sts_clr_i | input | 4 | Write-1-to-clear pulse for status bits |
| sts_mask_i | input | 4 | Alert mask, 1 = masked |
| pwm_dis_o | output | NPH | PWM disable per phase |
| sre_dis_o | output | NPH | Rectifier disable per phase |
| status_o | output | 4 | Sticky fault status |
| alert_o | output | 1 | Unmasked fault alert |

## Verification
The pin and comparator disables are combinational, so the bench drives them a little after a clock edge and samples them 1 ns later, before the next edge can register anything. An averaged trip takes three edges: the sample edge updates the average, the next edge registers the rail sum, and the third latches the disable mask. The bench checks the outputs after the second edge, where they must still be low, and after the third, where they must be high. Retry release, rectifier lag and latch release are counted in edges from the edge that registered the fault. Each of these is checked one edge before it is due and again on the edge it is due, so an off-by-one error fails a check.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam logic [1:0] RSP_IGNORE = 2'b00;
  localparam logic [1:0] RSP_RETRY  = 2'b10;

  localparam int unsigned NSTS  = 4;
  localparam int unsigned SB_PIN = 0;
  localparam int unsigned SB_CMP = 1;
  localparam int unsigned SB_OC  = 2;
  localparam int unsigned SB_UC  = 3;

  typedef enum logic [1:0] {
    CTL_RUN   = 2'b00,
    CTL_WAIT  = 2'b01,
    CTL_LATCH = 2'b10
  } ctl_st_e;
endpackage

// File: rtl/pfs_avg_bank.sv
module pfs_avg_bank #(
  parameter int NPH  = 4,
  parameter int DW   = 12,
  parameter int SW   = 4,
  parameter int PHW  = 2,
  parameter int SUMW = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_vld_i,
  input  logic [PHW-1:0]         smp_ph_i,
  input  logic signed [DW-1:0]   smp_data_i,
  input  logic [SW-1:0]          shift_i,
  output logic signed [SUMW-1:0] sum_o
);
  logic [NPH-1:0][DW-1:0] avg_all;
  logic signed [SUMW-1:0] sum_d, sum_q;

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    logic signed [DW-1:0] avg_q, avg_d;
    logic signed [DW:0]   diff, step;
    logic                 upd;

    always_comb begin
      upd   = smp_vld_i && (smp_ph_i == PHW'(k));
      diff  = $signed({smp_data_i[DW-1], smp_data_i}) - $signed({avg_q[DW-1], avg_q});
      step  = diff >>> shift_i;
      avg_d = upd ? (avg_q + step[DW-1:0]) : avg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) avg_q <= '0;
      else        avg_q <= avg_d;
    end

    assign avg_all[k] = avg_q;
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < NPH; k++) begin
      sum_d = sum_d + $signed({{(SUMW-DW){avg_all[k][DW-1]}}, avg_all[k]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/pfs_resp_ctrl.sv
module pfs_resp_ctrl
  import pfs_pkg::*;
#(
  parameter int NPH = 4,
  parameter int TW  = 16,
  parameter int RCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_rail_i,
  input  logic [NPH-1:0] evt_ph_i,
  input  logic           go_latch_i,
  input  logic           sts_zero_i,
  input  logic [TW-1:0]  retry_dly_i,
  input  logic [RCW-1:0] retry_max_i,
  output logic [NPH-1:0] off_mask_o
);
  ctl_st_e        st_q, st_d;
  logic [NPH-1:0] mask_q, mask_d, hit_mask;
  logic [TW-1:0]  wcnt_q, wcnt_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic           hit, wait_done;

  always_comb begin
    hit_mask  = {NPH{evt_rail_i}} | evt_ph_i;
    hit       = |hit_mask;
    wait_done = ({1'b0, wcnt_q} + 1'b1) >= {1'b0, retry_dly_i};
    st_d      = st_q;
    mask_d    = mask_q;
    wcnt_d    = wcnt_q;
    rcnt_d    = rcnt_q;
    case (st_q)
      CTL_RUN: begin
        if (hit) begin
          mask_d = hit_mask;
          wcnt_d = '0;
          if (go_latch_i || (rcnt_q >= retry_max_i)) st_d = CTL_LATCH;
          else                                       st_d = CTL_WAIT;
        end
      end
      CTL_WAIT: begin
        if (wait_done) begin
          st_d   = CTL_RUN;
          mask_d = '0;
          rcnt_d = rcnt_q + 1'b1;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      CTL_LATCH: begin
        if (sts_zero_i) begin
          st_d   = CTL_RUN;
          mask_d = '0;
          rcnt_d = '0;
        end
      end
      default: begin
        st_d   = CTL_RUN;
        mask_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CTL_RUN;
      mask_q <= '0;
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      mask_q <= mask_d;
      wcnt_q <= wcnt_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign off_mask_o = mask_q;
endmodule

// File: rtl/pfs_sre_delay.sv
module pfs_sre_delay #(
  parameter int NPH = 4,
  parameter int DLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] pwm_dis_i,
  input  logic [DLW-1:0] dly_i,
  output logic [NPH-1:0] sre_dis_o
);
  for (genvar k = 0; k < NPH; k++) begin : g_ph
    logic [DLW-1:0] cnt_q, cnt_d;

    always_comb begin
      if (!pwm_dis_i[k])      cnt_d = '0;
      else if (&cnt_q)        cnt_d = cnt_q;
      else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign sre_dis_o[k] = pwm_dis_i[k] && (cnt_q >= dly_i);
  end
endmodule

// File: rtl/phase_fault_sup.sv
module phase_fault_sup
  import pfs_pkg::*;
#(
  parameter  int NPH  = 4,
  parameter  int DW   = 12,
  parameter  int SW   = 4,
  parameter  int TW   = 16,
  parameter  int RCW  = 4,
  parameter  int DLW  = 8,
  localparam int PHW  = (NPH > 1) ? $clog2(NPH) : 1,
  localparam int SUMW = DW + PHW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPH-1:0]         ext_flt_i,
  input  logic [NPH-1:0]         cmp_trip_i,
  input  logic                   smp_vld_i,
  input  logic [PHW-1:0]         smp_ph_i,
  input  logic signed [DW-1:0]   smp_data_i,
  input  logic [SW-1:0]          cfg_shift_i,
  input  logic signed [SUMW-1:0] cfg_oc_lim_i,
  input  logic signed [SUMW-1:0] cfg_uc_lim_i,
  input  logic [1:0]             cfg_rsp_pin_i,
  input  logic [1:0]             cfg_rsp_cmp_i,
  input  logic [1:0]             cfg_rsp_avg_i,
  input  logic [TW-1:0]          cfg_retry_dly_i,
  input  logic [RCW-1:0]         cfg_retry_max_i,
  input  logic [DLW-1:0]         cfg_sre_dly_i,
  input  logic [NSTS-1:0]        sts_clr_i,
  input  logic [NSTS-1:0]        sts_mask_i,
  output logic [NPH-1:0]         pwm_dis_o,
  output logic [NPH-1:0]         sre_dis_o,
  output logic [NSTS-1:0]        status_o,
  output logic                   alert_o
);
  logic signed [SUMW-1:0] rail_sum;
  logic [NPH-1:0]         off_mask, cmp_evt;
  logic [NSTS-1:0]        sts_q, sts_d, sts_set;
  logic                   pin_evt, avg_evt, oc_hit, uc_hit, go_latch;

  pfs_avg_bank #(.NPH(NPH), .DW(DW), .SW(SW), .PHW(PHW), .SUMW(SUMW)) u_avg (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .smp_ph_i(smp_ph_i),
    .smp_data_i(smp_data_i), .shift_i(cfg_shift_i), .sum_o(rail_sum)
  );

  always_comb begin
    pin_evt  = (|ext_flt_i) && (cfg_rsp_pin_i != RSP_IGNORE);
    cmp_evt  = cmp_trip_i & {NPH{cfg_rsp_cmp_i != RSP_IGNORE}};
    oc_hit   = (cfg_rsp_avg_i != RSP_IGNORE) && (rail_sum > cfg_oc_lim_i);
    uc_hit   = (cfg_rsp_avg_i != RSP_IGNORE) && (rail_sum < cfg_uc_lim_i);
    avg_evt  = oc_hit || uc_hit;
    go_latch = (pin_evt && cfg_rsp_pin_i[0]) || ((|cmp_evt) && cfg_rsp_cmp_i[0]) ||
               (avg_evt && cfg_rsp_avg_i[0]);
    sts_set          = '0;
    sts_set[SB_PIN]  = pin_evt;
    sts_set[SB_CMP]  = |cmp_evt;
    sts_set[SB_OC]   = oc_hit;
    sts_set[SB_UC]   = uc_hit;
    sts_d            = (sts_q & ~sts_clr_i) | sts_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  pfs_resp_ctrl #(.NPH(NPH), .TW(TW), .RCW(RCW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_rail_i(pin_evt || avg_evt), .evt_ph_i(cmp_evt),
    .go_latch_i(go_latch), .sts_zero_i(sts_q == '0), .retry_dly_i(cfg_retry_dly_i),
    .retry_max_i(cfg_retry_max_i), .off_mask_o(off_mask)
  );

  assign pwm_dis_o = off_mask | {NPH{pin_evt}} | cmp_evt;

  pfs_sre_delay #(.NPH(NPH), .DLW(DLW)) u_sre (
    .clk(clk), .rst_n(rst_n), .pwm_dis_i(pwm_dis_o), .dly_i(cfg_sre_dly_i),
    .sre_dis_o(sre_dis_o)
  );

  assign status_o = sts_q;
  assign alert_o  = |(sts_q & ~sts_mask_i);
endmodule

// File: rtl/phase_fault_sup_chk.sv
module phase_fault_sup_chk #(
  parameter int NPH = 4,
  parameter int DLW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NPH-1:0] ext_flt_i,
  input logic [NPH-1:0] cmp_trip_i,
  input logic [1:0]     cfg_rsp_pin_i,
  input logic [1:0]     cfg_rsp_cmp_i,
  input logic [DLW-1:0] cfg_sre_dly_i,
  input logic [3:0]     sts_clr_i,
  input logic [NPH-1:0] pwm_dis_o,
  input logic [NPH-1:0] sre_dis_o,
  input logic [3:0]     status_o
);
  // R1
  pin_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ext_flt_i) && (cfg_rsp_pin_i != 2'b00)) |-> (&pwm_dis_o));

  // R2
  cmp_phase_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rsp_cmp_i != 2'b00) |-> ((cmp_trip_i & ~pwm_dis_o) == '0));

  // R3
  sre_needs_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sre_dis_o & ~pwm_dis_o) == '0));

  // R3
  sre_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sre_dly_i != '0) |-> ((sre_dis_o & ~$past(pwm_dis_o)) == '0));

  // R8
  sticky_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_i == '0) |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

bind phase_fault_sup phase_fault_sup_chk #(.NPH(NPH), .DLW(DLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_flt_i(ext_flt_i), .cmp_trip_i(cmp_trip_i),
  .cfg_rsp_pin_i(cfg_rsp_pin_i), .cfg_rsp_cmp_i(cfg_rsp_cmp_i),
  .cfg_sre_dly_i(cfg_sre_dly_i), .sts_clr_i(sts_clr_i), .pwm_dis_o(pwm_dis_o),
  .sre_dis_o(sre_dis_o), .status_o(status_o)
);

// File: tb/phase_fault_sup_tb.sv
module phase_fault_sup_tb;
  logic               clk = 1'b0;
  logic               rst_n;
  logic [3:0]         ext_flt, cmp_trip;
  logic               smp_vld;
  logic [1:0]         smp_ph;
  logic signed [11:0] smp_data;
  logic [3:0]         shift;
  logic signed [13:0] oc_lim, uc_lim;
  logic [1:0]         rsp_pin, rsp_cmp, rsp_avg;
  logic [15:0]        retry_dly;
  logic [3:0]         retry_max;
  logic [7:0]         sre_dly;
  logic [3:0]         sts_clr, sts_mask;
  logic [3:0]         pwm_dis, sre_dis, status;
  logic               alert;
  int                 n_tests = 0;
  int                 n_fail  = 0;
  bit                 done    = 1'b0;

  always #5 clk = ~clk;

  phase_fault_sup u_dut (
    .clk(clk), .rst_n(rst_n), .ext_flt_i(ext_flt), .cmp_trip_i(cmp_trip),
    .smp_vld_i(smp_vld), .smp_ph_i(smp_ph), .smp_data_i(smp_data), .cfg_shift_i(shift),
    .cfg_oc_lim_i(oc_lim), .cfg_uc_lim_i(uc_lim), .cfg_rsp_pin_i(rsp_pin),
    .cfg_rsp_cmp_i(rsp_cmp), .cfg_rsp_avg_i(rsp_avg), .cfg_retry_dly_i(retry_dly),
    .cfg_retry_max_i(retry_max), .cfg_sre_dly_i(sre_dly), .sts_clr_i(sts_clr),
    .sts_mask_i(sts_mask), .pwm_dis_o(pwm_dis), .sre_dis_o(sre_dis), .status_o(status),
    .alert_o(alert)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(logic [1:0] ph, int val);
    smp_vld  = 1'b1;
    smp_ph   = ph;
    smp_data = 12'(val);
    tick(1);
    smp_vld  = 1'b0;
  endtask

  task automatic clear_all();
    sts_clr = 4'hF;
    tick(1);
    sts_clr = 4'h0;
    tick(1);
  endtask

  task automatic t_reset();
    chk("R8 reset status", {28'd0, status}, 32'h0);
    chk("R1 reset pwm_dis", {28'd0, pwm_dis}, 32'h0);
    chk("R3 reset sre_dis", {28'd0, sre_dis}, 32'h0);
    chk("R9 reset alert", {31'd0, alert}, 32'h0);
  endtask

  task automatic t_pin_latch();
    rsp_pin = 2'b01;
    sre_dly = 8'd3;
    ext_flt = 4'b0100;
    #1;
    chk("R1 pin disables all phases", {28'd0, pwm_dis}, 32'hF);
    chk("R3 sre waits", {28'd0, sre_dis}, 32'h0);
    tick(1);
    ext_flt = 4'b0000;
    chk("R6 latched after pin drop", {28'd0, pwm_dis}, 32'hF);
    chk("R8 pin status bit0", {28'd0, status}, 32'h1);
    tick(1);
    chk("R3 sre before lag", {28'd0, sre_dis}, 32'h0);
    tick(1);
    chk("R3 sre on lag edge", {28'd0, sre_dis}, 32'hF);
    sts_mask = 4'b0001;
    #1;
    chk("R9 masked alert", {31'd0, alert}, 32'h0);
    sts_mask = 4'b0000;
    #1;
    chk("R9 unmasked alert", {31'd0, alert}, 32'h1);
    sts_clr = 4'b0001;
    tick(1);
    sts_clr = 4'b0000;
    chk("R6 still off one edge after clear", {28'd0, pwm_dis}, 32'hF);
    chk("R8 status cleared", {28'd0, status}, 32'h0);
    tick(1);
    chk("R6 released after clear", {28'd0, pwm_dis}, 32'h0);
    chk("R3 sre released", {28'd0, sre_dis}, 32'h0);
  endtask

  task automatic t_pin_ignore();
    rsp_pin = 2'b00;
    ext_flt = 4'b0001;
    #1;
    chk("R6 ignored pin no disable", {28'd0, pwm_dis}, 32'h0);
    tick(3);
    chk("R6 ignored pin no status", {28'd0, status}, 32'h0);
    chk("R6 ignored pin still enabled", {28'd0, pwm_dis}, 32'h0);
    ext_flt = 4'b0000;
    tick(1);
  endtask

  task automatic t_cmp_retry();
    rsp_cmp   = 2'b10;
    retry_dly = 16'd5;
    retry_max = 4'd2;
    sre_dly   = 8'd0;
    for (int r = 0; r < 2; r++) begin
      cmp_trip = 4'b0010;
      #1;
      chk("R2 cmp disables only its phase", {28'd0, pwm_dis}, 32'h2);
      chk("R3 zero lag sre", {28'd0, sre_dis}, 32'h2);
      tick(1);
      cmp_trip = 4'b0000;
      tick(4);
      chk("R7 still off before retry edge", {28'd0, pwm_dis}, 32'h2);
      tick(1);
      chk("R7 re-enabled on retry edge", {28'd0, pwm_dis}, 32'h0);
    end
    cmp_trip = 4'b0010;
    tick(1);
    cmp_trip = 4'b0000;
    tick(8);
    chk("R7 latched after retry limit", {28'd0, pwm_dis}, 32'h2);
    chk("R8 cmp status bit1", {28'd0, status}, 32'h2);
    clear_all();
    chk("R7 latch released", {28'd0, pwm_dis}, 32'h0);
    cmp_trip = 4'b0010;
    tick(1);
    cmp_trip = 4'b0000;
    tick(5);
    chk("R7 retry count reset by release", {28'd0, pwm_dis}, 32'h0);
    clear_all();
    rsp_cmp = 2'b00;
  endtask

  task automatic t_avg_oc();
    rsp_avg = 2'b01;
    shift   = 4'd0;
    oc_lim  = 14'sd1000;
    uc_lim  = -14'sd1000;
    send(2'd0, 500);
    send(2'd1, 500);
    tick(3);
    chk("R5 sum equal limit no trip", {28'd0, pwm_dis}, 32'h0);
    chk("R5 sum equal limit no status", {28'd0, status}, 32'h0);
    send(2'd2, 1);
    tick(1);
    chk("R5 oc not before third edge", {28'd0, pwm_dis}, 32'h0);
    tick(1);
    chk("R5 oc on third edge", {28'd0, pwm_dis}, 32'hF);
    chk("R8 oc status bit2", {28'd0, status}, 32'h4);
    send(2'd0, 0);
    send(2'd1, 0);
    send(2'd2, 0);
    tick(2);
    clear_all();
    chk("R6 oc latch released", {28'd0, pwm_dis}, 32'h0);
  endtask

  task automatic t_avg_uc();
    send(2'd0, -400);
    send(2'd1, -400);
    tick(3);
    chk("R5 uc above limit", {28'd0, pwm_dis}, 32'h0);
    send(2'd2, -300);
    tick(2);
    chk("R5 uc trips", {28'd0, pwm_dis}, 32'hF);
    chk("R8 uc status bit3", {28'd0, status}, 32'h8);
    send(2'd0, 0);
    send(2'd1, 0);
    send(2'd2, 0);
    tick(2);
    clear_all();
    chk("R6 uc latch released", {28'd0, pwm_dis}, 32'h0);
  endtask

  task automatic t_ema();
    shift  = 4'd1;
    oc_lim = 14'sd80;
    send(2'd0, 100);
    send(2'd0, 100);
    tick(3);
    chk("R4 avg 75 under limit", {28'd0, pwm_dis}, 32'h0);
    send(2'd0, 100);
    tick(1);
    chk("R4 avg 87 not yet", {28'd0, pwm_dis}, 32'h0);
    tick(1);
    chk("R4 avg 87 over limit", {28'd0, pwm_dis}, 32'hF);
    chk("R9 alert on oc", {31'd0, alert}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; ext_flt = '0; cmp_trip = '0; smp_vld = 1'b0; smp_ph = '0;
    smp_data = '0; shift = '0; oc_lim = 14'sd1000; uc_lim = -14'sd1000;
    rsp_pin = 2'b00; rsp_cmp = 2'b00; rsp_avg = 2'b00; retry_dly = 16'd1;
    retry_max = '0; sre_dly = '0; sts_clr = '0; sts_mask = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pin_latch();
    t_pin_ignore();
    t_cmp_retry();
    t_avg_oc();
    t_avg_uc();
    t_ema();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule